// File: doc/BRIEF.md
# Single-Channel DMA Control and Status

This block holds the control and status state of one DMA channel and runs its transfers. Software programs a source address, a destination address, a transfer count and a control word through a small register port. Once started, the channel moves one word per transfer. Each transfer is a read from the source followed by a write to the destination over a simple request/acknowledge memory port. After each completed transfer, both addresses advance by the transfer size.

Transfers run in one of two modes. In free-running mode the channel starts transfers on its own. In paced mode each transfer waits for a request pulse from a peripheral. A chip-level master enable and an NMI flag are inputs. A local address-error flag and a completion flag hold the channel off. Completion raises an interrupt once the final read has finished. The completion flag is cleared by a read-then-write-zero sequence.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the control word reads 0, the irq output is 0 and mem_req is 0. Registers are selected by reg_addr: 0 source, 1 destination, 2 count, 3 control. Control bits are: [0] run, [1] done, [2] irq enable, [3] paced mode, [4] address error, [6:5] size (0 byte, 1 half, 2 or 3 word).
- R2: In free-running mode, a transfer starts when all of these hold: run=1, master_en=1, done=0, nmi_flag=0, address error=0, count nonzero. Each transfer reads the source, then writes the read word to the destination.
- R3: The count decrements by one as each transfer starts. Once the count is 0, no further transfer starts.
- R4: The done bit sets in the same cycle that the count goes from 1 to 0, that is, when the final transfer begins.
- R5: After each completed write, the source and destination each advance by the transfer size (1, 2 or 4 bytes).
- R6: done clears only on a control write with bit 1 = 0 that follows a control read which returned done=1. A write of 1 to done has no effect, and a write of 0 without that prior read leaves done set.
- R7: While done=1, setting run starts no transfer.
- R8: In paced mode, each transfer waits for a dreq pulse. Without dreq, the count does not change.
- R9: irq equals irq-enable AND done AND "final read completed". It falls when done clears or irq-enable is written to 0.
- R10: Clearing run during a transfer ends it without further memory requests, and done stays 0. nmi_flag=1 or master_en=0 stops new transfers in the same way.
- R11: If a transfer would start while the source or destination is not aligned to the transfer size, the address error bit sets and no memory request issues. Writing 0 to bit 4 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the done clear) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| master_en | input | 1 | Chip-level DMA master enable |
| nmi_flag | input | 1 | Chip-level NMI stop flag |
| dreq | input | 1 | Peripheral transfer request (paced mode) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
The assertions assume that the memory acknowledges only while a request is pending. They also assume that mem_rdata is valid in the acknowledge cycle. The bench memory model ties mem_ack to mem_req through a stall switch, so both assumptions always hold. The checks also assume that software does not rewrite the address registers while a transfer is in flight. The stimulus writes those registers only while the channel is idle or blocked.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          master_en,
  input  logic          nmi_flag,
  input  logic          dreq,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;
  logic          run, done, ien, paced, aerr, armed, fin_rd;
  logic [1:0]    size;

  logic [AW-1:0] step;
  logic          misal, ready, launch, stop;

  assign step   = (size == 2'd0) ? AW'(1) : (size == 2'd1) ? AW'(2) : AW'(4);
  assign misal  = (size == 2'd0) ? 1'b0 :
                  (size == 2'd1) ? (src[0] | dst[0]) :
                  (|src[1:0]) | (|dst[1:0]);
  assign ready  = run & master_en & ~done & ~nmi_flag & ~aerr & (cnt != '0);
  assign launch = ready & (~paced | dreq);
  assign stop   = ~run | ~master_en | nmi_flag;

  assign irq       = ien & done & fin_rd;
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? dst : src;
  assign mem_wdata = hold;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(src);
      2'd1:    reg_rdata = 32'(dst);
      2'd2:    reg_rdata = 32'(cnt);
      default: reg_rdata = {25'd0, size, aerr, paced, ien, done, run};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src <= '0; dst <= '0; cnt <= '0; hold <= '0;
      run <= 1'b0; done <= 1'b0; ien <= 1'b0; paced <= 1'b0;
      aerr <= 1'b0; armed <= 1'b0; fin_rd <= 1'b0; size <= 2'd0;
    end else begin
      if (reg_rd && reg_addr == 2'd3 && done) armed <= 1'b1;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: src <= reg_wdata[AW-1:0];
          2'd1: dst <= reg_wdata[AW-1:0];
          2'd2: cnt <= reg_wdata[CW-1:0];
          default: begin
            run   <= reg_wdata[0];
            ien   <= reg_wdata[2];
            paced <= reg_wdata[3];
            size  <= reg_wdata[6:5];
            if (!reg_wdata[4]) aerr <= 1'b0;
            if (!reg_wdata[1] && armed) begin
              done   <= 1'b0;
              fin_rd <= 1'b0;
            end
            armed <= 1'b0;
          end
        endcase
      end
      case (st)
        S_IDLE: if (launch) begin
          if (misal) aerr <= 1'b1;
          else begin
            st  <= S_RD;
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              done   <= 1'b1;
              fin_rd <= 1'b0;
            end
          end
        end
        S_RD: if (stop) st <= S_IDLE;
              else if (mem_ack) begin
                hold <= mem_rdata;
                st   <= S_WR;
                if (cnt == '0) fin_rd <= 1'b1;
              end
        S_WR: if (stop) st <= S_IDLE;
              else if (mem_ack) begin
                src <= src + step;
                dst <= dst + step;
                st  <= S_IDLE;
              end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_chan_ctl_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          irq,
  input logic          ien,
  input logic          done,
  input logic          nmi_flag,
  input logic          aerr,
  input logic [CW-1:0] cnt,
  input logic [1:0]    size
);
  assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && done));
  assert_done_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cnt == '0));
  assert_done_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_req) |=> !mem_req);
  assert_nmi_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !mem_req) |=> !mem_req);
  assert_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && size >= 2'd2) |-> (mem_addr[1:0] == 2'b00));
  assert_aerr_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (aerr && !mem_req) |=> !mem_req);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .irq(irq), .ien(ien), .done(done),
  .nmi_flag(nmi_flag), .aerr(aerr), .cnt(cnt), .size(size)
);

// File: tb/sim_dma_chan_ctl.sv
module sim_dma_chan_ctl;
  localparam int CLK_PER = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic master_en = 1, nmi_flag = 0, dreq = 0;
  logic irq, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic ack_en = 1;
  logic [31:0] mem [64];
  int errs = 0, checks = 0;
  bit req_seen = 0, finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  dma_chan_ctl u0 (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .master_en, .nmi_flag, .dreq, .irq, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .mem_ack);

  assign mem_ack   = mem_req & ack_en;
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (mem_req) req_seen <= 1'b1;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[7:2]] <= mem_wdata;
  end

  localparam logic [31:0] VEC [4][3] = '{
    '{32'h00, 32'h80, 32'd3}, '{32'h10, 32'hC0, 32'd1},
    '{32'h40, 32'h20, 32'd5}, '{32'h04, 32'hF0, 32'd2}};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_arm(output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = 2'd3; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic clear_done();
    logic [31:0] d;
    rd_arm(d);
    wr(2'd3, 32'h40);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + i;
    idle(3); rst_n = 1;
    peek(2'd3, d); chk("R1 ctrl reset", d, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 req reset", mem_req, 0);

    for (int v = 0; v < 4; v++) begin
      wr(2'd0, VEC[v][0]); wr(2'd1, VEC[v][1]); wr(2'd2, VEC[v][2]);
      wr(2'd3, 32'h45);
      idle(3 * VEC[v][2] + 4);
      for (int k = 0; k < VEC[v][2]; k++)
        chk("R2 copied word", mem[VEC[v][1][7:2] + k], 32'hA500_0000 + VEC[v][0][7:2] + k);
      peek(2'd2, d); chk("R3 count zero", d, 0);
      peek(2'd3, d); chk("R4 done set", d[1], 1);
      peek(2'd1, d); chk("R5 dst advance", d, VEC[v][1] + 4 * VEC[v][2]);
      chk("R9 irq on", irq, 1);
      clear_done();
      peek(2'd3, d); chk("R6 done cleared", d[1], 0);
      chk("R9 irq off", irq, 0);
    end

    // R5 half size
    wr(2'd0, 32'h00); wr(2'd1, 32'h60); wr(2'd2, 2);
    wr(2'd3, 32'h21); idle(10);
    peek(2'd0, d); chk("R5 half src", d, 32'h04);
    peek(2'd1, d); chk("R5 half dst", d, 32'h64);
    // R6 write 0 without read keeps done; R9 irq-enable off
    wr(2'd3, 32'h20); peek(2'd3, d); chk("R6 no-read write", d[1], 1);
    // R7 run while done
    req_seen = 0; wr(2'd2, 2); wr(2'd3, 32'h41); idle(8);
    chk("R7 no req", req_seen, 0);
    peek(2'd2, d); chk("R7 count kept", d, 2);
    chk("R9 irq needs enable", irq, 0);
    clear_done();
    // R6 writing 1 to done has no effect
    wr(2'd3, 32'h42); peek(2'd3, d); chk("R6 write 1", d[1], 0);
    // R4/R9 final read not done yet
    wr(2'd0, 0); wr(2'd1, 32'h80); wr(2'd2, 1);
    ack_en = 0; wr(2'd3, 32'h45); idle(3);
    peek(2'd3, d); chk("R4 done at start", d[1], 1);
    chk("R9 irq waits read", irq, 0);
    ack_en = 1; idle(3);
    chk("R9 irq after read", irq, 1);
    wr(2'd3, 32'h40); chk("R9 ien off drops", irq, 0);
    clear_done();
    // R10 abort mid transfer
    wr(2'd2, 4); ack_en = 0; wr(2'd3, 32'h41); idle(3);
    chk("R10 req active", mem_req, 1);
    wr(2'd3, 32'h40); idle(2);
    chk("R10 req dropped", mem_req, 0);
    peek(2'd3, d); chk("R10 done clear", d[1], 0);
    peek(2'd2, d); chk("R3 count 3", d, 3);
    ack_en = 1;
    // R10 nmi and master enable
    nmi_flag = 1; req_seen = 0; wr(2'd3, 32'h41); idle(6);
    chk("R10 nmi blocks", req_seen, 0);
    wr(2'd3, 32'h40); nmi_flag = 0; master_en = 0;
    req_seen = 0; wr(2'd3, 32'h41); idle(6);
    chk("R10 master blocks", req_seen, 0);
    wr(2'd3, 32'h40); master_en = 1;
    // R8 paced
    wr(2'd0, 0); wr(2'd1, 32'h80);
    wr(2'd2, 3); wr(2'd3, 32'h49); idle(6);
    peek(2'd2, d); chk("R8 waits dreq", d, 3);
    @(negedge clk); dreq = 1; @(negedge clk); dreq = 0; idle(5);
    peek(2'd2, d); chk("R8 one transfer", d, 2);
    wr(2'd3, 32'h40);
    // R11 misaligned
    wr(2'd0, 32'h02); req_seen = 0; wr(2'd3, 32'h41); idle(5);
    peek(2'd3, d); chk("R11 aerr set", d[4], 1);
    chk("R11 no req", req_seen, 0);
    peek(2'd2, d); chk("R11 count kept", d, 2);
    wr(2'd3, 32'h40); peek(2'd3, d); chk("R11 aerr cleared", d[4], 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule